// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block takes in a configuration bitstream one bit per configuration clock. It first waits for a 4-bit start code. It then reads a 24-bit length word. After that it parses a fixed number of fixed-size frames. Each frame is a single start bit, a parameterised number of data bits and a 4-bit check field. Each good frame is presented on a data port with a one-cycle write strobe, for the memory array outside the block. A bad frame stops the loading. It raises a sticky error flag and a request to pull the shared open-drain init line low.

A daisy-chain output lets several loaders share one stream. In the normal chain mode, the header is passed through to the next device. The output is then held High while this device consumes its own frames. After that it follows the input again. In the enable-style chain mode, the length word is ignored and the output acts as an enable for the next device. It stays Low while this device loads and goes High once this device is complete. One data bit early in the first frame selects the fast configuration clock. Until that bit arrives, the select stays at the slow rate.

Top module: `cfg_stream_loader`

## Requirements
- R1: After a synchronous active-low reset, `err`, `init_low_req`, `done`, `frame_we` and `fast_clk_sel` are 0, and in normal chain mode `dout` equals `din`. Reset is the only way to clear a latched error.
- R2: The start code is detected as the bits 0,0,1,0 received in that order, and leading 1 bits are skipped. From reset through the last length bit, `dout` equals `din` in normal chain mode.
- R3: The 24 length bits follow the start code, most significant bit first. In normal chain mode, `done` rises after the clock edge that receives bit number length+4, counting every bit since reset. It rises only if all frames have loaded without error, and it then stays high.
- R4: In normal chain mode, `dout` is 1 from the first bit after the length word through the last bit of the last frame.
- R5: A frame is one start bit (0), DATA_BITS data bits and 4 check bits. The first data bit lands in `frame_data[0]`. The check bits arrive most significant first and must equal 0110. A good frame gives a one-cycle `frame_we` pulse, with `frame_data` holding its data, in the cycle after the last check bit.
- R6: A check field other than 0110 sets `err` and `init_low_req` after the edge that received the last check bit. No further `frame_we` follows, `done` never rises, and in normal chain mode `dout` stays 1.
- R7: A start bit of 1 is a frame error with the same effects as R6, raised after the edge that receives it.
- R8: In normal chain mode, once all frames have loaded, `dout` equals `din` again.
- R9: In enable-style chain mode, the length value is ignored. `done` rises after the fourth edge following the last frame bit, and `dout` equals 0 before that and 1 afterwards.
- R10: `fast_clk_sel` is 0 until data bit FAST_POS of the first frame has been received, and then holds that bit's value. Later frames do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; one stream bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial configuration bit |
| chain_mode | input | 1 | 0: pass-through chain, 1: enable-style chain |
| dout | output | 1 | Daisy-chain output |
| frame_data | output | DATA_BITS | Data bits of the last checked frame |
| frame_we | output | 1 | One-cycle write strobe for a good frame |
| err | output | 1 | Sticky frame error flag |
| init_low_req | output | 1 | Request to pull the open-drain init line low |
| done | output | 1 | Loading complete |
| fast_clk_sel | output | 1 | Fast configuration clock select |

## Verification
The properties assume several things about the inputs:
- `chain_mode` is steady whenever reset is released.
- Every rising edge carries a valid stream bit.
- Reset is asserted before the first bit arrives.

The bench applies these assumptions in the following way:
- It sets the mode before each reset pulse.
- It drives `din` only at falling edges.
- It counts every edge after reset release as a stream bit, so its expected `done` cycle uses the same count as the block.

Frame sizes in the bench come from the default parameters, so a check field never overlaps a write pulse.

// File: rtl/cfg_loader_pkg.sv
// Shared constants and the frame field type for the stream loader.
package cfg_loader_pkg;
    localparam int          CHECK_W    = 4;
    localparam logic [3:0]  START_CODE = 4'b0010;
    localparam logic [3:0]  CHECK_CODE = 4'b0110;

    typedef enum logic [1:0] {
        FLD_START,
        FLD_DATA,
        FLD_CHECK
    } field_e;
endpackage

// File: rtl/cfg_header_parser.sv
// Finds the start code in the serial stream and then shifts in the length
// word, most significant bit first. Assumes one bit per clock from reset.
module cfg_header_parser
    import cfg_loader_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic             hdr_done,
    output logic [LEN_W-1:0] length
);
    localparam int LC_W = $clog2(LEN_W);

    logic [2:0]      recent;
    logic            in_len;
    logic [LC_W-1:0] len_idx;

    // Purpose: hunt for the start code, then capture the length word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recent   <= 3'b111;
            in_len   <= 1'b0;
            len_idx  <= '0;
            length   <= '0;
            hdr_done <= 1'b0;
        end else if (!hdr_done) begin
            if (!in_len) begin
                recent <= {recent[1:0], din};
                if ({recent, din} == START_CODE) begin
                    in_len  <= 1'b1;
                    len_idx <= '0;
                end
            end else begin
                length  <= {length[LEN_W-2:0], din};
                len_idx <= len_idx + LC_W'(1);
                if (len_idx == LC_W'(LEN_W - 1)) begin
                    in_len   <= 1'b0;
                    hdr_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_frame_parser.sv
// Parses fixed-size frames once the header is complete: start bit, data
// bits (first bit into bit 0), then a check field compared to CHECK_CODE.
// Halts on the first error. Assumes DATA_BITS >= 2 and FRAME_COUNT >= 1.
module cfg_frame_parser
    import cfg_loader_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int FRAME_COUNT = 3,
    parameter int FAST_POS    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    input  logic                 enable,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_we,
    output logic                 frame_err,
    output logic                 frames_done,
    output logic                 fast_sel
);
    localparam int FRAME_LEN = 1 + DATA_BITS + CHECK_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int FIDX_W    = $clog2(FRAME_COUNT + 1);

    logic [POS_W-1:0]   pos;
    logic [FIDX_W-1:0]  fidx;
    logic [CHECK_W-2:0] chk;
    field_e             fld;
    logic               active;

    // Purpose: classify the current bit position within the frame.
    always_comb begin
        if (pos == '0)                         fld = FLD_START;
        else if (pos <= POS_W'(DATA_BITS))     fld = FLD_DATA;
        else                                   fld = FLD_CHECK;
    end

    assign active = enable && !frame_err && !frames_done;

    // Purpose: shift fields, check each frame and issue the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos         <= '0;
            fidx        <= '0;
            chk         <= '0;
            frame_data  <= '0;
            frame_we    <= 1'b0;
            frame_err   <= 1'b0;
            frames_done <= 1'b0;
            fast_sel    <= 1'b0;
        end else begin
            frame_we <= 1'b0;
            if (active) begin
                case (fld)
                    FLD_START: if (din) frame_err <= 1'b1;
                    FLD_DATA: begin
                        frame_data <= {din, frame_data[DATA_BITS-1:1]};
                        if (fidx == '0 && pos == POS_W'(FAST_POS + 1))
                            fast_sel <= din;
                    end
                    default:   chk <= {chk[CHECK_W-3:0], din};
                endcase
                if (pos == POS_W'(FRAME_LEN - 1)) begin
                    pos <= '0;
                    if ({chk, din} == CHECK_CODE) begin
                        frame_we <= 1'b1;
                        fidx     <= fidx + FIDX_W'(1);
                        if (fidx == FIDX_W'(FRAME_COUNT - 1))
                            frames_done <= 1'b1;
                    end else begin
                        frame_err <= 1'b1;
                    end
                end else begin
                    pos <= pos + POS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cfg_chain_ctrl.sv
// Drives the daisy-chain output and the done flag. It counts every clock
// since reset for the length rule, or counts tail clocks in enable-style
// chain mode. Assumes chain_mode is steady while out of reset.
module cfg_chain_ctrl #(
    parameter int LEN_W     = 24,
    parameter int TAIL_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             chain_mode,
    input  logic             hdr_done,
    input  logic             frames_done,
    input  logic             frame_err,
    input  logic [LEN_W-1:0] length,
    output logic             dout,
    output logic             done
);
    localparam int CNT_W  = LEN_W + 2;
    localparam int TAIL_W = $clog2(TAIL_CLKS + 1);

    logic [CNT_W-1:0]  clk_cnt;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  target;
    logic [TAIL_W-1:0] tail;

    assign cnt_next = clk_cnt + CNT_W'(1);
    assign target   = {2'b00, length} + CNT_W'(TAIL_CLKS);

    // Purpose: count stream clocks since reset, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)              clk_cnt <= '0;
        else if (~&clk_cnt)      clk_cnt <= cnt_next;
    end

    // Purpose: decide completion by length count or by tail clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
            done <= 1'b0;
        end else if (!done && frames_done && !frame_err) begin
            if (chain_mode) begin
                tail <= tail + TAIL_W'(1);
                if (tail == TAIL_W'(TAIL_CLKS - 1)) done <= 1'b1;
            end else if (cnt_next >= target) begin
                done <= 1'b1;
            end
        end
    end

    // Purpose: select the chain output level for the current load phase.
    always_comb begin
        if (chain_mode)                                   dout = done;
        else if (frame_err || (hdr_done && !frames_done)) dout = 1'b1;
        else                                              dout = din;
    end
endmodule

// File: rtl/cfg_stream_loader.sv
// Top of the serial configuration loader: header parser, frame parser and
// chain/done control. Assumes one stream bit per clock from reset release.
module cfg_stream_loader #(
    parameter int LEN_W       = 24,
    parameter int DATA_BITS   = 8,
    parameter int FRAME_COUNT = 3,
    parameter int FAST_POS    = 0,
    parameter int TAIL_CLKS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    input  logic                 chain_mode,
    output logic                 dout,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_we,
    output logic                 err,
    output logic                 init_low_req,
    output logic                 done,
    output logic                 fast_clk_sel
);
    logic             hdr_done;
    logic [LEN_W-1:0] length;
    logic             frames_done;

    cfg_header_parser #(.LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .din(din),
        .hdr_done(hdr_done), .length(length)
    );

    cfg_frame_parser #(
        .DATA_BITS(DATA_BITS), .FRAME_COUNT(FRAME_COUNT), .FAST_POS(FAST_POS)
    ) u_frm (
        .clk(clk), .rst_n(rst_n), .din(din), .enable(hdr_done),
        .frame_data(frame_data), .frame_we(frame_we), .frame_err(err),
        .frames_done(frames_done), .fast_sel(fast_clk_sel)
    );

    cfg_chain_ctrl #(.LEN_W(LEN_W), .TAIL_CLKS(TAIL_CLKS)) u_chain (
        .clk(clk), .rst_n(rst_n), .din(din), .chain_mode(chain_mode),
        .hdr_done(hdr_done), .frames_done(frames_done), .frame_err(err),
        .length(length), .dout(dout), .done(done)
    );

    assign init_low_req = err;
endmodule

// File: rtl/cfg_stream_loader_checks.sv
// Temporal properties of the loader, bound to its ports. Assumes reset is
// applied before the first stream bit and chain_mode is steady.
module cfg_stream_loader_checks (
    input logic clk,
    input logic rst_n,
    input logic chain_mode,
    input logic dout,
    input logic frame_we,
    input logic err,
    input logic done,
    input logic fast_clk_sel
);
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we |=> !frame_we);
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_err_blocks_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !frame_we);
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_done_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);
    p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode && err) |-> dout);
    p_chain_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && !done) |-> !dout);
    p_fast_no_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(fast_clk_sel));
endmodule

bind cfg_stream_loader cfg_stream_loader_checks u_checks (
    .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .dout(dout),
    .frame_we(frame_we), .err(err), .done(done), .fast_clk_sel(fast_clk_sel)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
    localparam int DW    = 8;
    localparam int FC    = 3;
    localparam int LW    = 24;
    localparam int FL    = 1 + DW + 4;
    localparam int HDR   = 4 + 4 + LW;
    localparam int FEND  = HDR + FC * FL;
    localparam int NBITS = FEND + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b1;
    logic          chain_mode = 1'b0;
    logic          dout;
    logic [DW-1:0] frame_data;
    logic          frame_we;
    logic          err;
    logic          init_low_req;
    logic          done;
    logic          fast_clk_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    cfg_stream_loader dut (
        .clk(clk), .rst_n(rst_n), .din(din), .chain_mode(chain_mode),
        .dout(dout), .frame_data(frame_data), .frame_we(frame_we),
        .err(err), .init_low_req(init_low_req), .done(done),
        .fast_clk_sel(fast_clk_sel)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Leaves the bench at a falling edge with reset released.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din   = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives one bit, records dout before the edge, returns at next falling edge.
    task automatic put(input logic b, output logic d_seen);
        din = b;
        #2;
        d_seen = dout;
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    function automatic logic done_after(input int n, input logic chain,
                                        input int len, input bit bad);
        if (bad || n < 1) return 1'b0;
        if (chain) return (n >= FEND + 4);
        return (n > FEND) && (n >= len + 4);
    endfunction

    task automatic run_stream(input string name, input logic chain, input int len,
                              input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                              input logic [DW-1:0] d2, input int bad_frame,
                              input logic bad_start);
        logic s [1:NBITS];
        logic [DW-1:0] dv [FC];
        logic [3:0] cp;
        int err_at;
        bit bad;
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bad = (bad_frame >= 0);
        chain_mode = chain;
        do_reset();
        for (int i = 1; i <= 4; i++) s[i] = 1'b1;
        s[5] = 1'b0; s[6] = 1'b0; s[7] = 1'b1; s[8] = 1'b0;
        for (int i = 0; i < LW; i++) s[9 + i] = len[LW - 1 - i];
        for (int f = 0; f < FC; f++) begin
            int b0;
            b0 = HDR + f * FL + 1;
            s[b0] = (f == bad_frame) && bad_start;
            for (int k = 0; k < DW; k++) s[b0 + 1 + k] = dv[f][k];
            cp = ((f == bad_frame) && !bad_start) ? 4'b0111 : 4'b0110;
            for (int k = 0; k < 4; k++) s[b0 + 1 + DW + k] = cp[3 - k];
        end
        for (int i = FEND + 1; i <= NBITS; i++) s[i] = i[0];
        err_at = bad ? (HDR + bad_frame * FL + 1 + (bad_start ? 0 : FL - 1)) : NBITS + 1;

        for (int n = 1; n <= NBITS; n++) begin
            logic dseen;
            logic exp_d;
            logic exp_we;
            logic exp_fast;
            string rq;
            int fi;
            put(s[n], dseen);
            // chain output seen before edge n
            if (chain) begin
                exp_d = done_after(n - 1, chain, len, bad);
                rq = "R9";
            end else if (n <= HDR) begin
                exp_d = s[n]; rq = "R2";
            end else if (n > err_at) begin
                exp_d = 1'b1; rq = bad_start ? "R7" : "R6";
            end else if (n <= FEND) begin
                exp_d = 1'b1; rq = "R4";
            end else begin
                exp_d = s[n]; rq = "R8";
            end
            check(rq, {name, " dout"}, 32'(dseen), 32'(exp_d));
            // error and init request after edge n
            rq = bad_start ? "R7" : "R6";
            check(rq, {name, " err"}, 32'(err), 32'(n >= err_at));
            check(rq, {name, " init_low_req"}, 32'(init_low_req), 32'(n >= err_at));
            // completion after edge n
            check(chain ? "R9" : "R3", {name, " done"}, 32'(done),
                  32'(done_after(n, chain, len, bad)));
            // write strobe and data (R5)
            fi = (n - HDR) / FL - 1;
            exp_we = (n > HDR) && ((n - HDR) % FL == 0) && (n <= FEND) && (n < err_at);
            check("R5", {name, " frame_we"}, 32'(frame_we), 32'(exp_we));
            if (exp_we) check("R5", {name, " frame_data"}, 32'(frame_data), 32'(dv[fi]));
            // fast clock select (R10)
            exp_fast = (n >= HDR + 2) && !(bad && bad_frame == 0 && bad_start) ? d0[0] : 1'b0;
            check("R10", {name, " fast_clk_sel"}, 32'(fast_clk_sel), 32'(exp_fast));
        end
    endtask

    task automatic test_reset();
        chain_mode = 1'b0;
        do_reset();
        check("R1", "reset err", 32'(err), 32'd0);
        check("R1", "reset init_low_req", 32'(init_low_req), 32'd0);
        check("R1", "reset done", 32'(done), 32'd0);
        check("R1", "reset frame_we", 32'(frame_we), 32'd0);
        check("R1", "reset fast_clk_sel", 32'(fast_clk_sel), 32'd0);
        din = 1'b0; #2;
        check("R1", "reset dout low", 32'(dout), 32'd0);
        din = 1'b1; #2;
        check("R1", "reset dout high", 32'(dout), 32'd1);
    endtask

    task automatic test_normal_load();
        run_stream("normal", 1'b0, FEND, 8'hA5, 8'h3C, 8'h81, -1, 1'b0);
    endtask

    task automatic test_longer_length();
        run_stream("long_len", 1'b0, FEND + 3, 8'h0F, 8'hF0, 8'h66, -1, 1'b0);
    endtask

    task automatic test_bad_check();
        run_stream("bad_check", 1'b0, FEND, 8'h11, 8'h22, 8'h33, 1, 1'b0);
    endtask

    task automatic test_bad_start();
        run_stream("bad_start", 1'b0, FEND, 8'hFF, 8'h00, 8'h5A, 2, 1'b0 | 1'b1);
    endtask

    task automatic test_chain();
        run_stream("chain", 1'b1, 5, 8'h5A, 8'hC3, 8'h7E, -1, 1'b0);
    endtask

    task automatic test_error_cleared();
        run_stream("chain_bad", 1'b1, 5, 8'h01, 8'h02, 8'h03, 0, 1'b0);
        do_reset();
        check("R1", "err cleared by reset", 32'(err), 32'd0);
        check("R1", "init request cleared by reset", 32'(init_low_req), 32'd0);
    endtask

    initial begin
        test_reset();
        test_normal_load();
        test_longer_length();
        test_bad_check();
        test_bad_start();
        test_chain();
        test_error_cleared();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule